// File: doc/BRIEF.md
# Four-Bit Two-Bus Arithmetic Datapath

This block is a small 4-bit arithmetic datapath. It holds four 4-bit registers, an ALU built around a single adder, and a shifter that moves data by 0 to 3 places. A two-bus scheme connects them, and each operation runs in a fixed two-step sequence.

In the first step, two registers are read onto the A and B buses. The ALU combines them into a result S, and the carry and zero flags are captured. In the second step, S travels over its own bus to the shifter. The shifted value then travels over a second bus back into the destination register.

The ALU has no separate gates for its logic functions. XOR is the adder sum with every internal carry held at zero. AND is the adder's carry-generate term. OR is built from the generate and propagate terms. Subtraction adds the complement of B with a carry-in of one. A simple host port lets the parent system load any register and read any register back.

Top module: `nib_datapath`

## Requirements
- R1: While `host_we` is high, the register at `host_addr` takes `host_wdata` at the clock edge. `host_rdata` always shows the register at `host_addr`, combinationally.
- R2: A `start` sampled high at edge N while the block is idle reads registers `sel_a` and `sel_b` in the cycle before edge N. `busy` is high from edge N to edge N+1. At edge N+1 the shifted result is written to register `sel_w`, and `done` is high for exactly the one cycle after edge N+1.
- R3: Opcode 3'b000 (add) gives S = (A + B) mod 16, and the carry flag is bit 4 of A + B.
- R4: Opcode 3'b001 (subtract) gives S = (A + ~B + 1) mod 16, and the carry flag is 1 exactly when A >= B (unsigned).
- R5: Opcode 3'b010 gives A AND B, 3'b011 gives A OR B, and 3'b100 gives A XOR B. Opcodes 3'b101 to 3'b111 pass A through unchanged. For all of these opcodes the carry flag is 0.
- R6: The shifter moves S by `shamt` places (0 to 3). `shdir` = 0 shifts toward the MSB (left) and `shdir` = 1 shifts toward the LSB (right). Vacated bit positions fill with 0.
- R7: The zero flag is 1 when the unshifted ALU result S is 0. Both flags are loaded at edge N and hold until the next accepted `start`.
- R8: A `start` that arrives while `busy` is high is ignored: no extra write-back and no extra `done`.
- R9: If a host write and a write-back target the same register at the same edge, the write-back value is stored.
- R10: After a synchronous reset, all registers, `busy`, `done` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 2 | Host register index for write and read |
| host_wdata | input | 4 | Host write data |
| host_rdata | output | 4 | Register contents at host_addr |
| start | input | 1 | Begin a two-step operation |
| sel_a | input | 2 | Register driven onto bus A |
| sel_b | input | 2 | Register driven onto bus B |
| sel_w | input | 2 | Destination register for write-back |
| op | input | 3 | ALU opcode |
| shamt | input | 2 | Shift amount 0..3 |
| shdir | input | 1 | Shift direction, 0 left, 1 right |
| busy | output | 1 | Write-back step pending |
| done | output | 1 | One-cycle pulse after write-back |
| carry_flag | output | 1 | Carry captured from the ALU |
| zero_flag | output | 1 | ALU result was zero |

## Verification
The flags and `busy` are due one edge after `start` is sampled. The new register value and `done` are due one edge later still. Inputs are driven on the falling edge, and each result is sampled on the falling edge that follows the rising edge that produces it. The flags are therefore read one falling edge after `start`, and the write-back is read through `host_rdata` together with `done` on the next falling edge. For the ignored-start and collision cases, the bench drives the extra stimulus during the busy cycle and checks through the host port that only the write-back value landed.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int DATA_W = 4;
    localparam int NREG   = 4;

    localparam logic [2:0] OP_ADD = 3'b000;
    localparam logic [2:0] OP_SUB = 3'b001;
    localparam logic [2:0] OP_AND = 3'b010;
    localparam logic [2:0] OP_OR  = 3'b011;
    localparam logic [2:0] OP_XOR = 3'b100;

    typedef enum logic {ST_IDLE, ST_WB} phase_t;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic [1:0]        dst;
        logic [1:0]        amt;
        logic              dir;
    } wb_req_t;

    function automatic logic is_logic_op(input logic [2:0] code);
        return !(code == OP_ADD || code == OP_SUB);
    endfunction
endpackage

// File: rtl/nib_regfile.sv
module nib_regfile #(
    parameter int W = 4,
    parameter int N = 4,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_en,
    input  logic [AW-1:0] hw_idx,
    input  logic [W-1:0]  hw_val,
    input  logic          dw_en,
    input  logic [AW-1:0] dw_idx,
    input  logic [W-1:0]  dw_val,
    input  logic [AW-1:0] ra_idx,
    input  logic [AW-1:0] rb_idx,
    input  logic [AW-1:0] rh_idx,
    output logic [W-1:0]  ra_val,
    output logic [W-1:0]  rb_val,
    output logic [W-1:0]  rh_val
);
    logic [W-1:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (dw_en && dw_idx == AW'(g))
                cells[g] <= dw_val;  // datapath write-back has priority (R9)
            else if (hw_en && hw_idx == AW'(g))
                cells[g] <= hw_val;
        end
    end

    assign ra_val = cells[ra_idx];
    assign rb_val = cells[rb_idx];
    assign rh_val = cells[rh_idx];
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W-1:0] bb, gen, prop, sum;
    logic         carry_end;

    always_comb begin
        logic sub, kill, c;
        sub  = (op == OP_SUB);
        kill = is_logic_op(op);
        bb   = sub ? ~b : b;
        gen  = a & bb;
        prop = a ^ bb;
        c    = sub;
        for (int i = 0; i < W; i++) begin
            sum[i] = prop[i] ^ c;
            c = kill ? 1'b0 : (gen[i] | (prop[i] & c));
        end
        carry_end = c;
    end

    always_comb begin
        cout = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin res = sum; cout = carry_end; end
            OP_AND:         res = gen;
            OP_OR:          res = gen | prop;
            OP_XOR:         res = sum;
            default:        res = a;
        endcase
    end
endmodule

// File: rtl/nib_shifter.sv
module nib_shifter #(
    parameter int W = 4,
    localparam int NAMT = W,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          dir,
    output logic [W-1:0]  dout
);
    logic [W-1:0] grp [NAMT];

    for (genvar k = 0; k < NAMT; k++) begin : g_amt
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic l_bit, r_bit;
            if (i >= k) begin : g_l
                assign l_bit = din[i-k];
            end else begin : g_lz
                assign l_bit = 1'b0;
            end
            if (i + k < W) begin : g_r
                assign r_bit = din[i+k];
            end else begin : g_rz
                assign r_bit = 1'b0;
            end
            assign grp[k][i] = dir ? r_bit : l_bit;
        end
    end

    assign dout = grp[amt];

    always_comb begin
        if (amt == '0)
            p_zero_shift_r6: assert (dout == din);
        if (amt != '0 && !dir)
            p_left_fill_r6: assert (dout[0] == 1'b0);
        if (amt != '0 && dir)
            p_right_fill_r6: assert (dout[W-1] == 1'b0);
    end
endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
    import nib_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NREG,
    localparam int AW = $clog2(N),
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    input  logic          start,
    input  logic [AW-1:0] sel_a,
    input  logic [AW-1:0] sel_b,
    input  logic [AW-1:0] sel_w,
    input  logic [2:0]    op,
    input  logic [SW-1:0] shamt,
    input  logic          shdir,
    output logic          busy,
    output logic          done,
    output logic          carry_flag,
    output logic          zero_flag
);
    phase_t       phase;
    logic [W-1:0] bus_a, bus_b, alu_s, shift_bus;
    logic         alu_c, accept;
    logic [W-1:0] s_hold;
    logic [AW-1:0] dst_hold;
    logic [SW-1:0] amt_hold;
    logic          dir_hold;

    assign accept = start && (phase == ST_IDLE);
    assign busy   = (phase == ST_WB);

    nib_regfile #(.W(W), .N(N)) i_rf (
        .clk(clk), .rst(rst),
        .hw_en(host_we), .hw_idx(host_addr), .hw_val(host_wdata),
        .dw_en(busy), .dw_idx(dst_hold), .dw_val(shift_bus),
        .ra_idx(sel_a), .rb_idx(sel_b), .rh_idx(host_addr),
        .ra_val(bus_a), .rb_val(bus_b), .rh_val(host_rdata)
    );

    nib_alu #(.W(W)) i_alu (
        .a(bus_a), .b(bus_b), .op(op), .res(alu_s), .cout(alu_c)
    );

    nib_shifter #(.W(W)) i_sh (
        .din(s_hold), .amt(amt_hold), .dir(dir_hold), .dout(shift_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= ST_IDLE;
            done       <= 1'b0;
            carry_flag <= 1'b0;
            zero_flag  <= 1'b0;
            s_hold     <= '0;
            dst_hold   <= '0;
            amt_hold   <= '0;
            dir_hold   <= 1'b0;
        end else begin
            done <= busy;
            if (accept) begin
                phase      <= ST_WB;
                s_hold     <= alu_s;
                dst_hold   <= sel_w;
                amt_hold   <= shamt;
                dir_hold   <= shdir;
                carry_flag <= alu_c;
                zero_flag  <= (alu_s == '0);
            end else if (busy) begin
                phase <= ST_IDLE;
            end
        end
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_follows_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done && !busy));
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(start && !busy) |=> ($stable(carry_flag) && $stable(zero_flag)));
    p_logic_no_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op != 3'b000 && op != 3'b001) |=> !carry_flag);
endmodule

// File: tb/test_nib_datapath.sv
module test_nib_datapath;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst = 1'b1;
    logic       host_we = 1'b0;
    logic [1:0] host_addr = '0;
    logic [3:0] host_wdata = '0;
    logic [3:0] host_rdata;
    logic       start = 1'b0;
    logic [1:0] sel_a = '0, sel_b = '0, sel_w = '0;
    logic [2:0] op = '0;
    logic [1:0] shamt = '0;
    logic       shdir = 1'b0;
    logic       busy, done, carry_flag, zero_flag;

    int n_tests = 0, n_fail = 0;
    logic [3:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_datapath i_nib_datapath (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start),
        .sel_a(sel_a), .sel_b(sel_b), .sel_w(sel_w), .op(op),
        .shamt(shamt), .shdir(shdir), .busy(busy), .done(done),
        .carry_flag(carry_flag), .zero_flag(zero_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_alu(input logic [2:0] o, input logic [3:0] a, input logic [3:0] b);
        int t;
        case (o)
            3'd0: begin t = int'(a) + int'(b); return 5'(t); end
            3'd1: return {(a >= b), 4'(int'(a) - int'(b))};
            3'd2: return {1'b0, a & b};
            3'd3: return {1'b0, a | b};
            3'd4: return {1'b0, a ^ b};
            default: return {1'b0, a};
        endcase
    endfunction

    function automatic logic [3:0] ref_shift(input logic [3:0] v, input int k, input logic d);
        return d ? (v >> k) : 4'(v << k);
    endfunction

    task automatic host_load(input logic [1:0] idx, input logic [3:0] v);
        host_we = 1'b1; host_addr = idx; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        model[idx] = v;
        check("R1 host readback", host_rdata, v);
    endtask

    task automatic run_op(input string req, input logic [1:0] a, input logic [1:0] b,
                          input logic [1:0] w, input logic [2:0] o, input int k, input logic d);
        logic [4:0] r;
        logic [3:0] expv;
        r = ref_alu(o, model[a], model[b]);
        expv = ref_shift(r[3:0], k, d);
        sel_a = a; sel_b = b; sel_w = w; op = o; shamt = 2'(k); shdir = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " busy"}, busy, 1);
        check({req, " carry"}, carry_flag, r[4]);
        check({"R7 zero ", req}, zero_flag, (r[3:0] == 0));
        host_addr = w;
        @(negedge clk);
        model[w] = expv;
        check({"R2 done ", req}, done, 1);
        check({req, " result"}, host_rdata, expv);
        @(negedge clk);
        check("R2 done single", done, 0);
    endtask

    task automatic t_reset;
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 carry", carry_flag, 0);
        check("R10 zero", zero_flag, 0);
        for (int i = 0; i < 4; i++) begin
            host_addr = 2'(i); #1;
            check("R10 reg", host_rdata, 0);
            model[i] = 4'h0;
        end
    endtask

    task automatic t_ignore_start;
        logic [4:0] r;
        host_load(2'd3, 4'h5);
        r = ref_alu(3'd0, model[0], model[1]);
        sel_a = 0; sel_b = 1; sel_w = 2; op = 3'd0; shamt = 0; shdir = 0; start = 1'b1;
        @(negedge clk);
        sel_w = 3; op = 3'd4;
        @(negedge clk);
        start = 1'b0;
        model[2] = r[3:0];
        check("R8 first done", done, 1);
        check("R8 carry kept", carry_flag, r[4]);
        host_addr = 3;
        @(negedge clk);
        check("R8 no second done", done, 0);
        check("R8 no busy", busy, 0);
        check("R8 target untouched", host_rdata, 4'h5);
    endtask

    task automatic t_collision;
        logic [4:0] r;
        r = ref_alu(3'd3, model[0], model[1]);
        sel_a = 0; sel_b = 1; sel_w = 2; op = 3'd3; shamt = 1; shdir = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        host_we = 1'b1; host_addr = 2; host_wdata = 4'hF;
        @(negedge clk);
        host_we = 1'b0;
        model[2] = r[3:0] >> 1;
        check("R9 write-back wins", host_rdata, model[2]);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        host_load(2'd0, 4'h9);
        host_load(2'd1, 4'h8);
        run_op("R3 add carry", 0, 1, 2, 3'd0, 0, 0);
        run_op("R4 sub no borrow", 0, 1, 3, 3'd1, 0, 0);
        run_op("R4 sub borrow", 1, 0, 3, 3'd1, 0, 0);
        run_op("R5 and", 0, 1, 2, 3'd2, 0, 0);
        run_op("R5 or", 0, 1, 2, 3'd3, 0, 0);
        run_op("R5 xor", 0, 1, 2, 3'd4, 0, 0);
        run_op("R5 reserved pass", 0, 1, 2, 3'd6, 0, 0);
        run_op("R7 zero via xor", 0, 0, 3, 3'd4, 0, 0);
        host_load(2'd0, 4'hB);
        host_load(2'd1, 4'h3);
        for (int k = 0; k < 4; k++) begin
            run_op("R6 shift left", 0, 1, 2, 3'd5, k, 0);
            run_op("R6 shift right", 0, 1, 3, 3'd5, k, 1);
        end
        for (int o = 0; o < 8; o++)
            run_op("R3 mixed op", 2, 1, 0, 3'(o), o % 4, 1'(o / 4));
        t_ignore_start();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule